// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block forms the 64-bit memory address for a fixed-point load/store pipeline. Each request carries a decoded instruction form, an update flag, the index of the base register, the base and index register values and a raw 16-bit immediate field. The block picks a base, builds an offset from that form, adds the two modulo 2^64, and returns the sum. For update forms it also asks for the sum to be written back to the base register. An update form that names register 0 as its base is flagged as invalid.

Requests enter through a valid/ready stream and results leave through a second one, one register stage later. A request is taken on a rising edge where `in_valid` and `in_ready` are both high. A result is consumed on a rising edge where `out_valid` and `out_ready` are both high. While a result waits unconsumed, it is held unchanged and the input side stalls. In a cycle where the result drains, a new request can be taken, so the block sustains one request per cycle when the consumer does not push back.

Top module: `lsu_ea_gen`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: For a non-update request (`in_update`=0) whose `in_ra_idx` is 0, the base is the constant 0 and `in_ra_val` has no effect on `out_ea`. Any other non-zero index uses `in_ra_val` as the base.
- R3: `in_form`=0 is the 16-bit displacement form. The offset is `in_imm` sign-extended to 64 bits.
- R4: `in_form`=1 is the word-scaled form. The offset is the sign extension of `in_imm[15:2]` with two zero bits appended below it, so `in_imm[1:0]` has no effect.
- R5: `in_form`=2 is the quad-scaled form. The offset is the sign extension of `in_imm[15:4]` with four zero bits appended below it, so `in_imm[3:0]` has no effect.
- R6: `in_form`=3 is the indexed form. The offset is `in_rb_val` and `in_imm` has no effect.
- R7: An update request always uses `in_ra_val` as the base, with no substitution of zero. When `in_ra_idx` is non-zero, it sets `out_wb_req`=1 with `out_wb_idx` equal to `in_ra_idx`. Non-update requests give `out_wb_req`=0.
- R8: An update request with `in_ra_idx`=0 gives `out_bad_form`=1 and `out_wb_req`=0. All other requests give `out_bad_form`=0.
- R9: The addition is modulo 2^64 and any carry out of bit 63 is dropped.
- R10: A request accepted on a clock edge appears on the outputs with `out_valid`=1 right after that edge. While `out_valid`=1 and `out_ready`=0, all result outputs stay unchanged.
- R11: `in_ready` equals `!out_valid || out_ready`. A request is accepted in the same cycle that a held result drains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request this cycle |
| in_form | input | 2 | Instruction form: 0 displacement, 1 word-scaled, 2 quad-scaled, 3 indexed |
| in_update | input | 1 | Update form: write the address back to the base register |
| in_ra_idx | input | 5 | Base register index |
| in_ra_val | input | 64 | Base register contents |
| in_rb_val | input | 64 | Index register contents |
| in_imm | input | 16 | Raw immediate field |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_ea | output | 64 | Effective address |
| out_wb_req | output | 1 | Write `out_ea` back to register `out_wb_idx` |
| out_wb_idx | output | 5 | Register index for the write-back |
| out_bad_form | output | 1 | Update form with base index 0 |

## Verification
Two things can happen on the same edge: a held result can drain and a new request can be accepted into the same output register. The bench drives `out_ready` at random against a steady stream of requests, and also holds it low for several cycles and then raises it while a fresh request waits. Every edge is judged against a bench model of the one-entry stage. That model checks that the old result stays fixed while it is stalled, and that the new one replaces it exactly on the draining edge with no cycle lost. The invalid flag and the write-back request come from one update request and are checked together, both for base index 0 and for non-zero indices.

// File: rtl/lsu_ea_pkg.sv
package lsu_ea_pkg;

  typedef enum logic [1:0] {
    EA_FORM_DISP  = 2'd0,
    EA_FORM_WSCL  = 2'd1,
    EA_FORM_QSCL  = 2'd2,
    EA_FORM_INDEX = 2'd3
  } ea_form_e;

endpackage

// File: rtl/ea_offset_sel.sv
module ea_offset_sel
  import lsu_ea_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int IMM_W    = 16,
  parameter int WSCL_LSB = 2,
  parameter int QSCL_LSB = 4
) (
  input  ea_form_e              form,
  input  logic [IMM_W-1:0]      imm,
  input  logic [XLEN-1:0]       rb_val,
  output logic [XLEN-1:0]       offset
);

  localparam int EXT_W = XLEN - IMM_W;
  localparam logic [IMM_W-1:0] WSCL_MASK = {{(IMM_W-WSCL_LSB){1'b1}}, {WSCL_LSB{1'b0}}};
  localparam logic [IMM_W-1:0] QSCL_MASK = {{(IMM_W-QSCL_LSB){1'b1}}, {QSCL_LSB{1'b0}}};

  logic [IMM_W-1:0] field;

  // Scaled forms drop the low field bits and keep the rest in place
  always_comb begin
    unique case (form)
      EA_FORM_WSCL: field = imm & WSCL_MASK;
      EA_FORM_QSCL: field = imm & QSCL_MASK;
      default:      field = imm;
    endcase
  end

  always_comb begin
    if (form == EA_FORM_INDEX) offset = rb_val;
    else                       offset = {{EXT_W{field[IMM_W-1]}}, field};
  end

endmodule

// File: rtl/ea_base_sel.sv
module ea_base_sel #(
  parameter int XLEN  = 64,
  parameter int IDX_W = 5
) (
  input  logic             update,
  input  logic [IDX_W-1:0] ra_idx,
  input  logic [XLEN-1:0]  ra_val,
  output logic [XLEN-1:0]  base,
  output logic             wb_req,
  output logic             bad_form
);

  logic ra_is_zero;

  assign ra_is_zero = (ra_idx == '0);

  // Index 0 reads as constant zero except for update forms
  assign base     = (ra_is_zero && !update) ? '0 : ra_val;
  assign wb_req   = update && !ra_is_zero;
  assign bad_form = update && ra_is_zero;

endmodule

// File: rtl/ea_out_stage.sv
module ea_out_stage #(
  parameter int XLEN  = 64,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [XLEN-1:0]  d_ea,
  input  logic             d_wb_req,
  input  logic [IDX_W-1:0] d_wb_idx,
  input  logic             d_bad,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [XLEN-1:0]  q_ea,
  output logic             q_wb_req,
  output logic [IDX_W-1:0] q_wb_idx,
  output logic             q_bad
);

  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_ea     <= '0;
      q_wb_req <= 1'b0;
      q_wb_idx <= '0;
      q_bad    <= 1'b0;
    end else if (take) begin
      q_ea     <= d_ea;
      q_wb_req <= d_wb_req;
      q_wb_idx <= d_wb_idx;
      q_bad    <= d_bad;
    end
  end

  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(q_ea) && $stable(q_wb_req)
                                   && $stable(q_wb_idx) && $stable(q_bad)));

  assert_stall_input_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

endmodule

// File: rtl/lsu_ea_gen.sv
module lsu_ea_gen
  import lsu_ea_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IDX_W = 5,
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_form,
  input  logic             in_update,
  input  logic [IDX_W-1:0] in_ra_idx,
  input  logic [XLEN-1:0]  in_ra_val,
  input  logic [XLEN-1:0]  in_rb_val,
  input  logic [IMM_W-1:0] in_imm,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [XLEN-1:0]  out_ea,
  output logic             out_wb_req,
  output logic [IDX_W-1:0] out_wb_idx,
  output logic             out_bad_form
);

  ea_form_e        form;
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offset;
  logic [XLEN-1:0] ea_sum;
  logic            wb_req;
  logic            bad_form;

  assign form = ea_form_e'(in_form);

  ea_base_sel #(.XLEN(XLEN), .IDX_W(IDX_W)) u_base (
    .update   (in_update),
    .ra_idx   (in_ra_idx),
    .ra_val   (in_ra_val),
    .base     (base),
    .wb_req   (wb_req),
    .bad_form (bad_form)
  );

  ea_offset_sel #(.XLEN(XLEN), .IMM_W(IMM_W)) u_off (
    .form   (form),
    .imm    (in_imm),
    .rb_val (in_rb_val),
    .offset (offset)
  );

  // Carry out of the top bit is discarded
  assign ea_sum = base + offset;

  ea_out_stage #(.XLEN(XLEN), .IDX_W(IDX_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .d_ea      (ea_sum),
    .d_wb_req  (wb_req),
    .d_wb_idx  (in_ra_idx),
    .d_bad     (bad_form),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .q_ea      (out_ea),
    .q_wb_req  (out_wb_req),
    .q_wb_idx  (out_wb_idx),
    .q_bad     (out_bad_form)
  );

  assert_accept_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_bad_blocks_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_bad_form) |-> !out_wb_req);

  assert_wb_target_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_wb_req) |-> (out_wb_idx != '0));

endmodule

// File: tb/lsu_ea_gen_test.sv
module lsu_ea_gen_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_form = 2'd0;
  logic        in_update = 1'b0;
  logic [4:0]  in_ra_idx = 5'd0;
  logic [63:0] in_ra_val = 64'd0;
  logic [63:0] in_rb_val = 64'd0;
  logic [15:0] in_imm = 16'd0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_ea;
  logic        out_wb_req;
  logic [4:0]  out_wb_idx;
  logic        out_bad_form;

  int checks = 0;
  int fails  = 0;

  logic        x_valid = 1'b0;
  logic [63:0] x_ea = '0;
  logic        x_wb = 1'b0;
  logic [4:0]  x_idx = '0;
  logic        x_bad = 1'b0;

  always #5 clk = ~clk;

  lsu_ea_gen uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_form(in_form), .in_update(in_update), .in_ra_idx(in_ra_idx),
    .in_ra_val(in_ra_val), .in_rb_val(in_rb_val), .in_imm(in_imm),
    .out_valid(out_valid), .out_ready(out_ready), .out_ea(out_ea),
    .out_wb_req(out_wb_req), .out_wb_idx(out_wb_idx), .out_bad_form(out_bad_form)
  );

  function automatic logic [63:0] model_ea(logic [1:0] f, logic u, logic [4:0] ra,
                                           logic [63:0] rav, logic [63:0] rbv,
                                           logic [15:0] imm);
    logic [63:0] b, o;
    b = (!u && ra == 5'd0) ? 64'd0 : rav;
    case (f)
      2'd0:    o = {{48{imm[15]}}, imm};
      2'd1:    o = {{48{imm[15]}}, imm[15:2], 2'b00};
      2'd2:    o = {{48{imm[15]}}, imm[15:4], 4'b0000};
      default: o = rbv;
    endcase
    return b + o;
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare_out(string req);
    check(out_valid == x_valid, {req, "/R10 valid"}, 64'(out_valid), 64'(x_valid));
    if (x_valid) begin
      check(out_ea == x_ea, {req, " ea"}, out_ea, x_ea);
      check(out_wb_req == x_wb, {req, "/R7 wb_req"}, 64'(out_wb_req), 64'(x_wb));
      check(out_bad_form == x_bad, {req, "/R8 bad"}, 64'(out_bad_form), 64'(x_bad));
      if (x_wb) check(out_wb_idx == x_idx, {req, "/R7 wb_idx"}, 64'(out_wb_idx), 64'(x_idx));
    end
  endtask

  // One cycle: drive at the falling edge, clock, compare at the next falling edge
  task automatic step(string req, bit rdy, bit vld, logic [1:0] f, bit u, logic [4:0] ra,
                      logic [63:0] rav, logic [63:0] rbv, logic [15:0] imm);
    bit exp_rdy, fire_in, fire_out;
    out_ready = rdy; in_valid = vld; in_form = f; in_update = u;
    in_ra_idx = ra; in_ra_val = rav; in_rb_val = rbv; in_imm = imm;
    #1;
    exp_rdy = !x_valid || rdy;
    check(in_ready == exp_rdy, {req, "/R11 in_ready"}, 64'(in_ready), 64'(exp_rdy));
    fire_in  = vld && exp_rdy;
    fire_out = x_valid && rdy;
    @(posedge clk);
    if (fire_in) begin
      x_valid = 1'b1;
      x_ea    = model_ea(f, u, ra, rav, rbv, imm);
      x_wb    = u && (ra != 5'd0);
      x_bad   = u && (ra == 5'd0);
      x_idx   = ra;
    end else if (fire_out) begin
      x_valid = 1'b0;
    end
    @(negedge clk);
    compare_out(req);
  endtask

  initial begin
    #(200000 * 10);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'd0);
    check(in_ready == 1'b1, "R1 in_ready", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corner cases
    step("R2 zero base", 1, 1, 2'd0, 0, 5'd0, 64'hDEAD_BEEF_0000_1111, 64'd7, 16'h0040);
    step("R2 reg base", 1, 1, 2'd0, 0, 5'd9, 64'h1000, 64'd7, 16'h0040);
    step("R3 negative disp", 1, 1, 2'd0, 0, 5'd4, 64'h1000, 64'd0, 16'hFFF0);
    step("R4 low bits ignored", 1, 1, 2'd1, 0, 5'd4, 64'h2000, 64'd0, 16'h8007);
    step("R5 low bits ignored", 1, 1, 2'd2, 0, 5'd4, 64'h2000, 64'd0, 16'h7FFF);
    step("R6 indexed", 1, 1, 2'd3, 0, 5'd6, 64'h100, 64'h0000_0001_0000_0000, 16'hFFFF);
    step("R7 update ra0 base", 1, 1, 2'd0, 1, 5'd0, 64'h5000, 64'd0, 16'h0010);
    step("R8 update bad", 1, 1, 2'd3, 1, 5'd0, 64'h10, 64'h20, 16'h0);
    step("R7 update wb", 1, 1, 2'd1, 1, 5'd17, 64'h3000, 64'd0, 16'h0104);
    step("R9 wrap", 1, 1, 2'd0, 0, 5'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 16'h0002);
    step("R9 wrap idx", 1, 1, 2'd3, 1, 5'd3, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0001, 16'h0);
    // Back-pressure: hold, then drain and accept together
    step("R10 load", 0, 1, 2'd0, 1, 5'd8, 64'hAAAA, 64'd0, 16'h0001);
    step("R10 hold", 0, 1, 2'd2, 0, 5'd2, 64'h1, 64'd0, 16'h0030);
    step("R10 hold", 0, 1, 2'd2, 0, 5'd2, 64'h1, 64'd0, 16'h0030);
    step("R11 drain+accept", 1, 1, 2'd2, 0, 5'd2, 64'h1, 64'd0, 16'h0030);
    step("R11 drain", 1, 0, 2'd0, 0, 5'd0, 64'd0, 64'd0, 16'd0);
    step("R10 idle", 1, 0, 2'd0, 0, 5'd0, 64'd0, 64'd0, 16'd0);

    // Random stream with random back-pressure
    for (int i = 0; i < 600; i++) begin
      logic [4:0] ra;
      ra = ($urandom % 4 == 0) ? 5'd0 : 5'($urandom);
      step("R3-6 random", ($urandom % 3) != 0, ($urandom % 4) != 0, 2'($urandom),
           1'($urandom), ra, {$urandom, $urandom}, {$urandom, $urandom}, 16'($urandom));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule